// File: doc/BRIEF.md
# Gamma Channel Command Decoder

This block sits behind a byte-level serial slave and turns each bus transaction into operations on eighteen 10-bit output channels. The slave hands it start, stop, received-byte and read-request strobes. The block returns the next byte to send on a read. The first byte written after a start is a pointer. Its two top bits pick the operation: register access, an acquire of one channel, or an acquire of all channels. Its low six bits give a channel or register address.

Each channel holds two registers. The input register takes bus writes. The output register drives the analog side. A written 16-bit word can do one of three things: update only its input register, move every input register into the output bank, or become a request to store the value in nonvolatile memory. Multi-word transfers step the pointer automatically. A separate load port lets the nonvolatile side write recalled values into both registers of a channel.

Top module: `gamma_cmd_decoder`

## Requirements
- R1: After reset, every input and output register holds 10'h200, all request pulses are low, and the first read byte is 8'h02.
- R2: Pointer byte bits 7:6 select the operation: 2'b00 register access, 2'b10 acquire all channels, 2'b01 acquire one channel, 2'b11 nothing. Data bytes that follow a pointer byte with bits 7:6 other than 2'b00 change no register.
- R3: Address 0x00–0x0F selects channels 0–15, and 0x12 and 0x13 select channels 16 and 17. Writes to any other address are dropped without any bank transfer, and channel reads from them return 16'h0000.
- R4: A word arrives high byte first, and only bits 9:0 are stored. A register changes only on the second byte; a start or stop that follows a single byte discards that byte.
- R5: A completed word with bit 15 set copies every input register, including the one just written, into the output bank at the same clock edge. With bit 15 clear, only the input register changes.
- R6: A word whose bits 15:14 are 2'b01 is a store request. It writes both registers of its channel at once and raises nv_req_o for exactly one cycle, with the channel index and value. A second such word in the same transaction is ignored entirely, though the pointer still advances.
- R7: Every completed write word and every completed two-byte read advances the pointer by one, through the gap addresses. The pointer stops at 0x13 and does not advance from any address above 0x13.
- R8: A read returns the high byte first. A channel read returns its input register with bits 15:10 zero.
- R9: Address 0x3C reads as REV_WORD, 0x3D as ID_WORD, and 0x3F as wcount_i zero-extended. Each gives its value only as the first word after a start or pointer byte, and later words of that burst read 16'h0000. Writes to these addresses change nothing.
- R10: A stop after a 2'b10 pointer byte pulses acq_all_o for one cycle. A stop after a 2'b01 pointer byte with a valid channel address pulses acq_one_o with acq_chan_o set to the channel index. A gap address gives no pulse, and a start before the stop cancels the request.
- R11: nv_ld_i writes nv_ld_data_i into both registers of channel nv_ld_idx_i. When it falls in the same cycle as a completed bus word, the load wins for its own channel, and the other channels still follow R5.
- R12: Reset drops any store pulse at once and returns the pointer to address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up or general-call) |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| byte_valid_i | input | 1 | A written byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | The slave has taken rd_byte_o |
| rd_byte_o | output | 8 | Byte to send on the next read slot |
| wcount_i | input | 4 | Write-count code from the nonvolatile side |
| nv_ld_i | input | 1 | Load a recalled value into one channel |
| nv_ld_idx_i | input | 5 | Channel index for the load |
| nv_ld_data_i | input | 10 | Value to load |
| nv_req_o | output | 1 | One-cycle nonvolatile store request |
| nv_chan_o | output | 5 | Channel index of the store request |
| nv_data_o | output | 10 | Value of the store request |
| acq_all_o | output | 1 | One-cycle request to recall all channels |
| acq_one_o | output | 1 | One-cycle request to recall one channel |
| acq_chan_o | output | 5 | Channel index for the single recall |
| out_bank_o | output | 180 | Output registers, channel i at bits 10*i+9:10*i |

## Verification
A recall load from the nonvolatile side can land in the same cycle as the second byte of a bus word that sets bit 15. That one clock edge then has to apply the bank-wide transfer and the single-channel overwrite together. The bench provokes this by asserting nv_ld_i in the same cycle as the low byte. The word targets the loaded channel, and a different channel already holds an input value that has not yet reached its output. The result passes only if the loaded channel shows the load value in both registers and the other channel's output has taken its pending input.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS  = 2'b00,
        OP_ACQ_ONE = 2'b01,
        OP_ACQ_ALL = 2'b10,
        OP_NONE    = 2'b11
    } op_e;

    localparam logic [1:0] STORE_TAG = 2'b01;

endpackage

// File: rtl/gcd_addr_map.sv
module gcd_addr_map #(
    parameter int NMAIN    = 16,
    parameter int NCOM     = 2,
    parameter int COM_BASE = 18,
    parameter int IW       = 5
) (
    input  logic [5:0]    addr,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (int'(addr) < NMAIN) begin
            hit = 1'b1;
            idx = IW'(int'(addr));
        end else if (int'(addr) >= COM_BASE && int'(addr) < COM_BASE + NCOM) begin
            hit = 1'b1;
            idx = IW'(int'(addr) - COM_BASE + NMAIN);
        end
    end

endmodule

// File: rtl/gcd_bank.sv
module gcd_bank #(
    parameter int          NCH     = 18,
    parameter int          DW      = 10,
    parameter int          IW      = 5,
    parameter logic [DW-1:0] RST_VAL = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              store_en,
    input  logic              xfer_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_val,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [DW-1:0]     ld_val,
    output logic [NCH*DW-1:0] in_flat,
    output logic [NCH*DW-1:0] out_flat
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] in_d, in_q, out_d, out_q;

        always_comb begin
            in_d  = in_q;
            out_d = out_q;
            if (wr_en && wr_idx == IW'(g)) begin
                in_d = wr_val;
            end
            if (xfer_en) begin
                out_d = in_d;
            end
            if (store_en && wr_idx == IW'(g)) begin
                out_d = wr_val;
            end
            if (ld_en && ld_idx == IW'(g)) begin
                in_d  = ld_val;
                out_d = ld_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q  <= RST_VAL;
                out_q <= RST_VAL;
            end else begin
                in_q  <= in_d;
                out_q <= out_d;
            end
        end

        assign in_flat[g*DW +: DW]  = in_q;
        assign out_flat[g*DW +: DW] = out_q;
    end

endmodule

// File: rtl/gcd_read_mux.sv
module gcd_read_mux #(
    parameter int          NCH      = 18,
    parameter int          DW       = 10,
    parameter int          IW       = 5,
    parameter int          CW       = 4,
    parameter int          ADR_REV  = 60,
    parameter int          ADR_ID   = 61,
    parameter int          ADR_CNT  = 63,
    parameter logic [15:0] REV_WORD = 16'h0003,
    parameter logic [15:0] ID_WORD  = 16'h6A1C
) (
    input  logic [5:0]        addr,
    input  logic              hit,
    input  logic [IW-1:0]     idx,
    input  logic [NCH*DW-1:0] in_flat,
    input  logic              first_word,
    input  logic [CW-1:0]     wcount,
    input  logic              lo_sel,
    output logic [7:0]        rd_byte
);

    logic [15:0] word;

    always_comb begin
        word = '0;
        if (hit) begin
            word[DW-1:0] = in_flat[idx*DW +: DW];
        end else if (first_word) begin
            if (addr == 6'(ADR_REV)) begin
                word = REV_WORD;
            end else if (addr == 6'(ADR_ID)) begin
                word = ID_WORD;
            end else if (addr == 6'(ADR_CNT)) begin
                word[CW-1:0] = wcount;
            end
        end
    end

    assign rd_byte = lo_sel ? word[7:0] : word[15:8];

endmodule

// File: rtl/gamma_cmd_decoder.sv
module gamma_cmd_decoder
    import gcd_pkg::*;
#(
    parameter int          NMAIN    = 16,
    parameter int          NCOM     = 2,
    parameter int          COM_BASE = 18,
    parameter int          DW       = 10,
    parameter int          CW       = 4,
    parameter int          ADR_REV  = 60,
    parameter int          ADR_ID   = 61,
    parameter int          ADR_CNT  = 63,
    parameter logic [15:0] REV_WORD = 16'h0003,
    parameter logic [15:0] ID_WORD  = 16'h6A1C,
    localparam int         NCH       = NMAIN + NCOM,
    localparam int         IW        = $clog2(NCH),
    localparam int         LAST_ADDR = COM_BASE + NCOM - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic              rd_req_i,
    output logic [7:0]        rd_byte_o,
    input  logic [CW-1:0]     wcount_i,
    input  logic              nv_ld_i,
    input  logic [IW-1:0]     nv_ld_idx_i,
    input  logic [DW-1:0]     nv_ld_data_i,
    output logic              nv_req_o,
    output logic [IW-1:0]     nv_chan_o,
    output logic [DW-1:0]     nv_data_o,
    output logic              acq_all_o,
    output logic              acq_one_o,
    output logic [IW-1:0]     acq_chan_o,
    output logic [NCH*DW-1:0] out_bank_o
);

    typedef struct packed {
        logic [5:0]    ptr;
        logic          exp_ptr;
        op_e           op;
        logic          hi_have;
        logic [1:0]    hi_mode;
        logic [DW-9:0] hi_val;
        logic          rd_lo;
        logic          rd_first_done;
        logic          nv_used;
        logic          acq_all_pend;
        logic          acq_one_pend;
        logic [IW-1:0] acq_chan;
        logic          acq_all;
        logic          acq_one;
        logic          nv_req;
        logic [IW-1:0] nv_chan;
        logic [DW-1:0] nv_data;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              p_hit, b_hit;
    logic [IW-1:0]     p_idx, b_idx;
    logic              wr_en, st_en, xf_en;
    logic [DW-1:0]     wr_val;
    logic [5:0]        ptr_adv;
    logic [NCH*DW-1:0] in_flat;

    gcd_addr_map #(.NMAIN(NMAIN), .NCOM(NCOM), .COM_BASE(COM_BASE), .IW(IW)) u_map_ptr (
        .addr (st_q.ptr),
        .hit  (p_hit),
        .idx  (p_idx)
    );

    gcd_addr_map #(.NMAIN(NMAIN), .NCOM(NCOM), .COM_BASE(COM_BASE), .IW(IW)) u_map_byte (
        .addr (byte_i[5:0]),
        .hit  (b_hit),
        .idx  (b_idx)
    );

    assign wr_val  = {st_q.hi_val, byte_i};
    assign ptr_adv = (st_q.ptr < 6'(LAST_ADDR)) ? st_q.ptr + 6'd1 : st_q.ptr;

    always_comb begin
        st_d         = st_q;
        st_d.acq_all = 1'b0;
        st_d.acq_one = 1'b0;
        st_d.nv_req  = 1'b0;
        wr_en        = 1'b0;
        st_en        = 1'b0;
        xf_en        = 1'b0;

        if (stop_i || start_i) begin
            st_d.acq_all       = stop_i & st_q.acq_all_pend;
            st_d.acq_one       = stop_i & st_q.acq_one_pend;
            st_d.acq_all_pend  = 1'b0;
            st_d.acq_one_pend  = 1'b0;
            st_d.exp_ptr       = 1'b1;
            st_d.hi_have       = 1'b0;
            st_d.rd_lo         = 1'b0;
            st_d.rd_first_done = 1'b0;
            st_d.nv_used       = 1'b0;
        end else if (byte_valid_i) begin
            if (st_q.exp_ptr) begin
                st_d.ptr           = byte_i[5:0];
                st_d.op            = op_e'(byte_i[7:6]);
                st_d.exp_ptr       = 1'b0;
                st_d.hi_have       = 1'b0;
                st_d.rd_lo         = 1'b0;
                st_d.rd_first_done = 1'b0;
                st_d.acq_all_pend  = (op_e'(byte_i[7:6]) == OP_ACQ_ALL);
                st_d.acq_one_pend  = (op_e'(byte_i[7:6]) == OP_ACQ_ONE) && b_hit;
                st_d.acq_chan      = b_idx;
            end else if (st_q.op == OP_ACCESS) begin
                if (!st_q.hi_have) begin
                    st_d.hi_have = 1'b1;
                    st_d.hi_mode = byte_i[7:6];
                    st_d.hi_val  = byte_i[DW-9:0];
                end else begin
                    st_d.hi_have = 1'b0;
                    st_d.ptr     = ptr_adv;
                    if (p_hit) begin
                        if (st_q.hi_mode == STORE_TAG) begin
                            if (!st_q.nv_used) begin
                                wr_en        = 1'b1;
                                st_en        = 1'b1;
                                st_d.nv_used = 1'b1;
                                st_d.nv_req  = 1'b1;
                                st_d.nv_chan = p_idx;
                                st_d.nv_data = wr_val;
                            end
                        end else begin
                            wr_en = 1'b1;
                            xf_en = st_q.hi_mode[1];
                        end
                    end
                end
            end
        end else if (rd_req_i) begin
            if (!st_q.rd_lo) begin
                st_d.rd_lo = 1'b1;
            end else begin
                st_d.rd_lo         = 1'b0;
                st_d.rd_first_done = 1'b1;
                st_d.ptr           = ptr_adv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.exp_ptr <= 1'b1;
            st_q.op      <= OP_ACCESS;
        end else begin
            st_q <= st_d;
        end
    end

    gcd_bank #(.NCH(NCH), .DW(DW), .IW(IW), .RST_VAL(DW'(1) << (DW - 1))) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .store_en (st_en),
        .xfer_en  (xf_en),
        .wr_idx   (p_idx),
        .wr_val   (wr_val),
        .ld_en    (nv_ld_i),
        .ld_idx   (nv_ld_idx_i),
        .ld_val   (nv_ld_data_i),
        .in_flat  (in_flat),
        .out_flat (out_bank_o)
    );

    gcd_read_mux #(
        .NCH(NCH), .DW(DW), .IW(IW), .CW(CW),
        .ADR_REV(ADR_REV), .ADR_ID(ADR_ID), .ADR_CNT(ADR_CNT),
        .REV_WORD(REV_WORD), .ID_WORD(ID_WORD)
    ) u_rd (
        .addr       (st_q.ptr),
        .hit        (p_hit),
        .idx        (p_idx),
        .in_flat    (in_flat),
        .first_word (!st_q.rd_first_done),
        .wcount     (wcount_i),
        .lo_sel     (st_q.rd_lo),
        .rd_byte    (rd_byte_o)
    );

    assign nv_req_o   = st_q.nv_req;
    assign nv_chan_o  = st_q.nv_chan;
    assign nv_data_o  = st_q.nv_data;
    assign acq_all_o  = st_q.acq_all;
    assign acq_one_o  = st_q.acq_one;
    assign acq_chan_o = st_q.acq_chan;

endmodule

// File: rtl/gcd_checker.sv
module gcd_checker #(
    parameter int BW        = 180,
    parameter int LAST_ADDR = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          stop_i,
    input logic          byte_valid_i,
    input logic          rd_req_i,
    input logic          nv_ld_i,
    input logic          nv_req_o,
    input logic          acq_all_o,
    input logic          acq_one_o,
    input logic [BW-1:0] out_bank_o,
    input logic [5:0]    ptr
);

    // R6
    nv_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_o |=> !nv_req_o);

    // R6
    nv_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_o |-> $past(byte_valid_i));

    // R10
    acq_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_all_o || acq_one_o) |-> $past(stop_i));

    // R10
    acq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_all_o, acq_one_o}));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(byte_valid_i) && !$past(nv_ld_i)) |-> $stable(out_bank_o));

    // R7
    ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !byte_valid_i && !start_i && !stop_i && ptr == 6'(LAST_ADDR))
        |=> (ptr == 6'(LAST_ADDR)));

endmodule

bind gamma_cmd_decoder gcd_checker #(.BW(NCH*DW), .LAST_ADDR(LAST_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .rd_req_i     (rd_req_i),
    .nv_ld_i      (nv_ld_i),
    .nv_req_o     (nv_req_o),
    .acq_all_o    (acq_all_o),
    .acq_one_o    (acq_one_o),
    .out_bank_o   (out_bank_o),
    .ptr          (st_q.ptr)
);

// File: tb/gamma_cmd_decoder_bench.sv
`timescale 1ns/1ps
module gamma_cmd_decoder_bench;

    localparam logic [15:0] REV_W = 16'h0003;
    localparam logic [15:0] ID_W  = 16'h6A1C;
    localparam int NV = 10;
    // ptr, hi, lo, expected read word, channel to check (FF none), expected output value
    localparam logic [63:0] VEC [0:NV-1] = '{
        {8'h02, 8'h01, 8'h55, 16'h0155, 8'd2,   16'h0200},
        {8'h05, 8'h83, 8'hFF, 16'h03FF, 8'd2,   16'h0155},
        {8'h12, 8'h02, 8'h34, 16'h0234, 8'd16,  16'h0200},
        {8'h10, 8'h81, 8'h11, 16'h0000, 8'd16,  16'h0200},
        {8'h13, 8'hFE, 8'h01, 16'h0201, 8'd16,  16'h0234},
        {8'h3D, 8'h12, 8'h34, ID_W,     8'hFF,  16'h0000},
        {8'h3C, 8'h00, 8'h00, REV_W,    8'hFF,  16'h0000},
        {8'h3E, 8'h00, 8'h00, 16'h0000, 8'hFF,  16'h0000},
        {8'h3F, 8'h00, 8'h00, 16'h0009, 8'hFF,  16'h0000},
        {8'h07, 8'h00, 8'h00, 16'h0000, 8'd7,   16'h0200}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0, rd_req_i = 1'b0;
    logic [7:0]   byte_i = '0;
    logic [7:0]   rd_byte_o;
    logic [3:0]   wcount_i = 4'h9;
    logic         nv_ld_i = 1'b0;
    logic [4:0]   nv_ld_idx_i = '0;
    logic [9:0]   nv_ld_data_i = '0;
    logic         nv_req_o, acq_all_o, acq_one_o;
    logic [4:0]   nv_chan_o, acq_chan_o;
    logic [9:0]   nv_data_o;
    logic [179:0] out_bank_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gamma_cmd_decoder #(.REV_WORD(REV_W), .ID_WORD(ID_W)) u_gamma_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .rd_req_i(rd_req_i),
        .rd_byte_o(rd_byte_o), .wcount_i(wcount_i), .nv_ld_i(nv_ld_i),
        .nv_ld_idx_i(nv_ld_idx_i), .nv_ld_data_i(nv_ld_data_i),
        .nv_req_o(nv_req_o), .nv_chan_o(nv_chan_o), .nv_data_o(nv_data_o),
        .acq_all_o(acq_all_o), .acq_one_o(acq_one_o), .acq_chan_o(acq_chan_o),
        .out_bank_o(out_bank_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] outv(input int ch);
        return out_bank_o[ch*10 +: 10];
    endfunction

    task automatic t_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        #1;
    endtask

    task automatic t_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        #1;
    endtask

    task automatic t_byte(input logic [7:0] b);
        @(negedge clk) begin byte_i = b; byte_valid_i = 1'b1; end
        @(negedge clk) byte_valid_i = 1'b0;
        #1;
    endtask

    task automatic t_byte_ld(input logic [7:0] b, input logic [4:0] ix, input logic [9:0] v);
        @(negedge clk) begin
            byte_i = b; byte_valid_i = 1'b1;
            nv_ld_i = 1'b1; nv_ld_idx_i = ix; nv_ld_data_i = v;
        end
        @(negedge clk) begin byte_valid_i = 1'b0; nv_ld_i = 1'b0; end
        #1;
    endtask

    task automatic t_load(input logic [4:0] ix, input logic [9:0] v);
        @(negedge clk) begin nv_ld_i = 1'b1; nv_ld_idx_i = ix; nv_ld_data_i = v; end
        @(negedge clk) nv_ld_i = 1'b0;
        #1;
    endtask

    task automatic t_word(input logic [15:0] w);
        t_byte(w[15:8]);
        t_byte(w[7:0]);
    endtask

    task automatic t_read(output logic [15:0] w);
        w[15:8] = rd_byte_o;
        @(negedge clk) rd_req_i = 1'b1;
        @(negedge clk) rd_req_i = 1'b0;
        #1;
        w[7:0] = rd_byte_o;
        @(negedge clk) rd_req_i = 1'b1;
        @(negedge clk) rd_req_i = 1'b0;
        #1;
    endtask

    task automatic read_at(input logic [7:0] p, output logic [15:0] w);
        t_start();
        t_byte(p);
        t_start();
        t_read(w);
        t_stop();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // Table walk: R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            t_start();
            t_byte(VEC[i][63:56]);
            t_byte(VEC[i][55:48]);
            t_byte(VEC[i][47:40]);
            t_stop();
            read_at(VEC[i][63:56], w);
            chk($sformatf("R3/R8/R9 row %0d read", i), 32'(w), 32'(VEC[i][39:24]));
            if (VEC[i][23:16] != 8'hFF)
                chk($sformatf("R4/R5 row %0d out", i), 32'(outv(int'(VEC[i][23:16]))), 32'(VEC[i][15:0]));
        end

        // R6 store pulse, then R12 reset drops it at once
        t_start();
        t_byte(8'h01);
        t_word(16'h4005);
        chk("R6 store pulse", 32'(nv_req_o), 32'd1);
        chk("R6 store chan", 32'(nv_chan_o), 32'd1);
        chk("R6 store data", 32'(nv_data_o), 32'h005);
        rst_n = 1'b0;
        #1;
        chk("R12 store pulse cleared", 32'(nv_req_o), 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 first read byte", 32'(rd_byte_o), 32'h02);
        chk("R1 out ch0", 32'(outv(0)), 32'h200);
        chk("R1 out ch17", 32'(outv(17)), 32'h200);
        chk("R1 out ch7", 32'(outv(7)), 32'h200);
        chk("R1 pulses low", 32'({nv_req_o, acq_all_o, acq_one_o}), 32'd0);

        // R12 pointer at zero, R11 lone load
        t_load(5'd0, 10'h0AA);
        chk("R11 load out", 32'(outv(0)), 32'h0AA);
        t_read(w);
        chk("R12 ptr zero read", 32'(w), 32'h00AA);

        // R4 partial word dropped by stop and by start
        t_start(); t_byte(8'h04); t_byte(8'h01); t_stop();
        read_at(8'h04, w);
        chk("R4 stop after one byte", 32'(w), 32'h0200);
        t_start(); t_byte(8'h04); t_byte(8'h01); t_start();
        t_read(w);
        t_stop();
        chk("R4 start after one byte", 32'(w), 32'h0200);

        // R7 multi-word write through gaps and saturation
        t_start(); t_byte(8'h0F);
        t_word(16'h0011); t_word(16'h0022); t_word(16'h0033);
        t_word(16'h0044); t_word(16'h0055); t_word(16'h0066);
        t_stop();
        t_start(); t_byte(8'h0F); t_start();
        t_read(w); chk("R7 burst 0x0F", 32'(w), 32'h0011);
        t_read(w); chk("R7 burst 0x10", 32'(w), 32'h0000);
        t_read(w); chk("R7 burst 0x11", 32'(w), 32'h0000);
        t_read(w); chk("R7 burst 0x12", 32'(w), 32'h0044);
        t_read(w); chk("R7 burst 0x13 saturated write", 32'(w), 32'h0066);
        t_read(w); chk("R7 burst read saturated", 32'(w), 32'h0066);
        t_stop();

        // R9 identity only as first word
        t_start(); t_byte(8'h3D); t_start();
        t_read(w); chk("R9 id first word", 32'(w), 32'(ID_W));
        t_read(w); chk("R9 id second word", 32'(w), 32'h0000);
        t_stop();

        // R6 one store per transaction
        t_start(); t_byte(8'h03);
        t_word(16'h4123);
        chk("R6 pulse ch3", 32'({nv_req_o, nv_chan_o, nv_data_o}), 32'({1'b1, 5'd3, 10'h123}));
        chk("R6 out ch3 immediate", 32'(outv(3)), 32'h123);
        t_word(16'h4077);
        chk("R6 second store no pulse", 32'(nv_req_o), 32'd0);
        t_stop();
        read_at(8'h04, w);
        chk("R6 second store ignored", 32'(w), 32'h0200);
        t_start(); t_byte(8'h04); t_word(16'h4077);
        chk("R6 new transaction store", 32'({nv_req_o, nv_chan_o}), 32'({1'b1, 5'd4}));
        t_stop();

        // R10 and R2 acquire decoding
        t_start(); t_byte(8'h80); t_stop();
        chk("R10 acquire all", 32'({acq_all_o, acq_one_o}), 32'b10);
        t_start(); t_byte(8'h45); t_stop();
        chk("R10 acquire one", 32'({acq_all_o, acq_one_o, acq_chan_o}), 32'({1'b0, 1'b1, 5'd5}));
        t_start(); t_byte(8'h50); t_stop();
        chk("R10 acquire gap none", 32'({acq_all_o, acq_one_o}), 32'b00);
        t_start(); t_byte(8'h80); t_start(); t_stop();
        chk("R10 acquire cancelled", 32'({acq_all_o, acq_one_o}), 32'b00);
        t_start(); t_byte(8'hC2); t_word(16'h0010); t_stop();
        read_at(8'h02, w);
        chk("R2 op 11 data ignored", 32'(w), 32'h0200);
        t_start(); t_byte(8'h82); t_word(16'h0020); t_stop();
        chk("R2 op 10 pulse", 32'(acq_all_o), 32'd1);
        read_at(8'h02, w);
        chk("R2 op 10 data ignored", 32'(w), 32'h0200);

        // R11 load and bit-15 transfer in one cycle
        t_start(); t_byte(8'h01); t_word(16'h00EE); t_stop();
        chk("R5 no transfer bit15 clear", 32'(outv(1)), 32'h200);
        t_start(); t_byte(8'h06); t_byte(8'h81);
        t_byte_ld(8'h11, 5'd6, 10'h0CD);
        t_stop();
        chk("R11 load wins out", 32'(outv(6)), 32'h0CD);
        chk("R5 transfer with load", 32'(outv(1)), 32'h0EE);
        read_at(8'h06, w);
        chk("R11 load wins input", 32'(w), 32'h00CD);

        done = 1'b1;
        finish_run();
    end

endmodule